// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, called A and B, and passes data in either direction with every bit inverted. Each direction has its own storage register, loaded by its own capture strobe. For each direction a select input decides whether the driven port carries the live value of the opposite bus or the stored value for that direction. Two output enables, one active high for the B port and one active low for the A port, decide whether each port drives.

The block is written for an FPGA fabric. Everything runs on one system clock, and the two capture strobes are level inputs that are synchronous to that clock. A register loads when its strobe is seen low at one clock edge and high at the next. Each bus pin is split into an input vector, an output vector and an output-enable vector, and the wired bus is resolved outside the block.

The data outputs and enables are registered. The live path therefore shows its result one clock after the input is sampled. When both selects are low and both ports are enabled, each port drives the inverse of the other port's input. This loop keeps both buses at their last value after every outside driver has been released.

Top module: `xcvr_dual_reg`

## Requirements
- R1: The A-to-B register loads `a_in` at a clock edge where `cap_ab` is high and was low at the previous edge. It keeps its value at every other edge.
- R2: The B-to-A register loads `b_in` at a clock edge where `cap_ba` is high and was low at the previous edge. It keeps its value at every other edge.
- R3: Capture depends on nothing but the strobe. It happens whatever the selects and enables are, and even while the block is driving the bus being captured. For example, B is driven from A live with A = 0x3C, `cap_ba` is pulsed, and then A is driven from storage. The A port then carries 0x3C.
- R4: One clock after sampling, `b_out` equals the bitwise inverse of `a_in` when `sel_ab` is 0. It equals the bitwise inverse of the A-to-B register when `sel_ab` is 1.
- R5: One clock after sampling, `a_out` equals the bitwise inverse of `b_in` when `sel_ba` is 0. It equals the bitwise inverse of the B-to-A register when `sel_ba` is 1.
- R6: One clock after sampling, `b_oe` is all ones when `oe_ab` is 1 and all zeros otherwise. `a_oe` is all ones when `oe_ba_n` is 0 and all zeros otherwise.
- R7: With `oe_ab` = 0 and `oe_ba_n` = 1, both `a_oe` and `b_oe` are all zeros one clock later, so neither bus is driven.
- R8: With both selects 0 and both ports enabled, each bus holds its last value after its outside driver is released. For example, A driven to 0x5A from outside and then released stays at 0x5A.
- R9: While `rst` is high, both registers are cleared to zero. From the edge after `rst` is sampled high, both outputs and both enable vectors are zero, whatever `oe_ab` and `oe_ba_n` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_ab | input | 1 | Capture strobe of the A-to-B register (rising level) |
| cap_ba | input | 1 | Capture strobe of the B-to-A register (rising level) |
| sel_ab | input | 1 | B-port source: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | A-port source: 0 live B, 1 stored B-to-A |
| oe_ab | input | 1 | B-port drive enable, active high |
| oe_ba_n | input | 1 | A-port drive enable, active low |
| a_in | input | WIDTH | Resolved A-bus value |
| a_out | output | WIDTH | Value driven onto the A bus |
| a_oe | output | WIDTH | A-bus output enable, all ones or all zeros |
| b_in | input | WIDTH | Resolved B-bus value |
| b_out | output | WIDTH | Value driven onto the B bus |
| b_oe | output | WIDTH | B-bus output enable, all ones or all zeros |

## Verification
The case that needs care is a register capture landing in the same cycle as the output that reads that register through the stored path. In that cycle the output must still carry the old register contents, and the new contents appear one clock later. Randomised strobes and selects provoke this often. A behavioural model, compared every clock, judges each output against the pre-edge register value. A directed run also captures a bus that the block itself is driving. The stored value must be what the block drove, not the value from outside.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W = 8;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic fire;

  assign fire = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (fire) q <= din;
    end
  end

  // R1 / R2: load on a detected rising strobe, hold otherwise
  a_r1_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_q) |=> (q == $past(din)));
  a_r1_r2_keep: assert property (@(posedge clk) disable iff (rst)
    !(strobe && !strobe_q) |=> $stable(q));
  a_r9_clear: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         en,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe
);
  logic [W-1:0] src;

  always_comb src = sel ? stored : live;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      doe  <= '0;
    end else begin
      dout <= ~src;
      doe  <= {W{en}};
    end
  end

  // R4 / R5: inverted live or stored value one clock later
  a_r4_r5_live: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (dout == ~$past(live)));
  a_r4_r5_stored: assert property (@(posedge clk) disable iff (rst)
    sel |=> (dout == ~$past(stored)));
  // R6: enable vector follows the enable level
  a_r6_on: assert property (@(posedge clk) disable iff (rst)
    en |=> (doe == {W{1'b1}}));
  a_r6_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (doe == '0));
  // R9: reset forces the port off
  a_r9_off: assert property (@(posedge clk)
    rst |=> (doe == '0 && dout == '0));
endmodule

// File: rtl/xcvr_dual_reg.sv
module xcvr_dual_reg #(
  parameter int WIDTH = xcvr_pkg::XCVR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  logic [WIDTH-1:0] reg_ab;
  logic [WIDTH-1:0] reg_ba;

  xcvr_store #(.W(WIDTH)) u_store_ab (
    .clk(clk), .rst(rst), .strobe(cap_ab), .din(a_in), .q(reg_ab));

  xcvr_store #(.W(WIDTH)) u_store_ba (
    .clk(clk), .rst(rst), .strobe(cap_ba), .din(b_in), .q(reg_ba));

  xcvr_drive #(.W(WIDTH)) u_drive_b (
    .clk(clk), .rst(rst), .sel(sel_ab), .en(oe_ab),
    .live(a_in), .stored(reg_ab), .dout(b_out), .doe(b_oe));

  xcvr_drive #(.W(WIDTH)) u_drive_a (
    .clk(clk), .rst(rst), .sel(sel_ba), .en(~oe_ba_n),
    .live(b_in), .stored(reg_ba), .dout(a_out), .doe(a_oe));

  // R7: isolation setting turns both ports off
  a_r7_isolate: assert property (@(posedge clk) disable iff (rst)
    (!oe_ab && oe_ba_n) |=> (a_oe == '0 && b_oe == '0));
  // R6: active-low A enable polarity
  a_r6_a_polarity: assert property (@(posedge clk) disable iff (rst)
    !oe_ba_n |=> (a_oe == {WIDTH{1'b1}}));
endmodule

// File: tb/sim_xcvr_dual_reg.sv
module sim_xcvr_dual_reg;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, oe_ab = 0, oe_ba_n = 1;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic ext_a_en = 0, ext_b_en = 0;
  logic [W-1:0] a_bus, b_bus, a_out, a_oe, b_out, b_oe;
  int errors = 0, checks = 0;
  bit started = 0, done = 0;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  assign a_bus = ext_a_en ? ext_a : (a_out & a_oe);
  assign b_bus = ext_b_en ? ext_b : (b_out & b_oe);

  xcvr_dual_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe));

  // behavioural reference model
  logic [W-1:0] m_rab = '0, m_rba = '0, m_aout = '0, m_bout = '0;
  logic m_aoe = 0, m_boe = 0, m_pab = 0, m_pba = 0;
  logic m_sab = 0, m_sba = 0, m_iso = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_rab <= '0; m_rba <= '0; m_aout <= '0; m_bout <= '0;
      m_aoe <= 0; m_boe <= 0; m_pab <= 0; m_pba <= 0; m_iso <= 0;
    end else begin
      if (cap_ab && !m_pab) m_rab <= a_bus;
      if (cap_ba && !m_pba) m_rba <= b_bus;
      m_pab <= cap_ab;
      m_pba <= cap_ba;
      m_bout <= sel_ab ? ~m_rab : ~a_bus;
      m_aout <= sel_ba ? ~m_rba : ~b_bus;
      m_boe <= oe_ab;
      m_aoe <= !oe_ba_n;
      m_iso <= !oe_ab && oe_ba_n;
    end
    m_sab <= sel_ab;
    m_sba <= sel_ba;
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(m_sab ? "R4 stored path (R1 register)" : "R4 live path", b_out, m_bout);
      chk(m_sba ? "R5 stored path (R2 register)" : "R5 live path", a_out, m_aout);
      chk(m_iso ? "R7 isolation b_oe" : "R6 b_oe", b_oe, {W{m_boe}});
      chk(m_iso ? "R7 isolation a_oe" : "R6 a_oe", a_oe, {W{m_aoe}});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    step(3);
    chk("R9 reset a_oe", a_oe, '0);
    chk("R9 reset b_oe", b_oe, '0);
    chk("R9 reset b_out", b_out, '0);
    rst = 0;
    // randomised phase: strobes, selects, enables, outside drivers
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cap_ab = lf[0]; cap_ba = lf[1]; sel_ab = lf[2]; sel_ba = lf[3];
      oe_ab = lf[4]; oe_ba_n = lf[5];
      ext_a_en = lf[6] | lf[7]; ext_b_en = lf[8] | lf[9];
      ext_a = lf[15:8] ^ 8'h96; ext_b = lf[7:0];
      step(1);
    end
    // R3: capture a bus the block itself drives
    cap_ab = 0; cap_ba = 0; sel_ab = 0; sel_ba = 0;
    oe_ab = 1; oe_ba_n = 1; ext_a_en = 1; ext_a = 8'h3C; ext_b_en = 0;
    step(2);
    chk("R3 B bus driven from A", b_bus, 8'hC3);
    cap_ba = 1; step(1); cap_ba = 0;
    sel_ba = 1; oe_ba_n = 0; ext_a_en = 0; oe_ab = 0;
    step(2);
    chk("R3 stored self-driven value on A", a_bus, 8'h3C);
    // R8: feedback hold
    sel_ab = 0; sel_ba = 0; oe_ab = 1; oe_ba_n = 0;
    ext_a_en = 1; ext_a = 8'h5A; ext_b_en = 0;
    step(3);
    ext_a_en = 0;
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk("R8 A bus holds", a_bus, 8'h5A);
      chk("R8 B bus holds", b_bus, 8'hA5);
    end
    // R7: isolation
    oe_ab = 0; oe_ba_n = 1;
    step(2);
    chk("R7 isolated a_oe", a_oe, '0);
    chk("R7 isolated b_oe", b_oe, '0);
    // R1 directed capture then stored read
    ext_a_en = 1; ext_a = 8'h81; sel_ab = 1; oe_ab = 1;
    cap_ab = 1; step(1); cap_ab = 0; ext_a = 8'h00;
    step(2);
    chk("R1 stored A-to-B on B", b_out, 8'h7E);
    // R9: reset with enables asserted
    oe_ab = 1; oe_ba_n = 0; rst = 1;
    step(2);
    chk("R9 reset overrides a_oe", a_oe, '0);
    chk("R9 reset overrides b_oe", b_oe, '0);
    rst = 0; sel_ab = 1;
    step(2);
    chk("R9 register cleared", b_out, 8'hFF);
    done = 1;
    report();
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule